// File: doc/BRIEF.md
# Serial flash command sequencer

This block turns one high-level request into the full series of byte transfers that a serial configuration flash needs. A requester picks a transaction class (identify, status read, status write, data read, program, sector erase) and supplies an offset, a byte count and, for writes, a stream of data bytes. The block then drives a byte-wide full-duplex shifter below it. It controls the chip-select framing, puts the command and a three-byte address on the link, and inserts a separate write-enable frame wherever the flash demands one. Program requests are cut into pieces that never cross a page, and after each program or erase the busy flag is polled until the flash reports idle. The block returns the received bytes one per pulse and raises a one-cycle done flag at the end.

The shifter interface works one byte at a time. The block pulses `link_go` with the byte on `link_tx`. The shifter later pulses `link_done` with the byte it clocked in on `link_rx`. Only one byte is ever outstanding. Payload bytes are mirrored within the byte in both directions, because the flash stores configuration data least significant bit first. Command, address and status bytes are not mirrored.

Top module: `sflash_seq`

## Requirements
- R1: Command bytes per class: identify 0xAB, status read 0x05, status write 0x01, data read 0x03, program 0x02, sector erase 0xD8, write enable 0x06. The busy poll uses 0x05. The class codes on `req_op` are 0 identify, 1 status read, 2 status write, 3 data read, 4 program, 5 sector erase.
- R2: For data read, program and sector erase, the opcode is followed in the same frame by three address bytes, most significant first.
- R3: Each program chunk, sector erase and status write is preceded by a frame that contains only 0x06.
- R4: After a program chunk or an erase, frames of {0x05, 0x00} repeat until the received status byte has bit 0 clear. Bit 1 of that byte has no effect on the sequence.
- R5: A program request of N bytes at offset A is split so that no frame crosses a page. The first chunk has min(PAGE - A mod PAGE, N) bytes, and each following chunk starts on a page boundary. Each chunk has its own write-enable frame and its own poll.
- R6: Identify sends 0xAB, then three 0x00 dummy bytes, then one 0x00 to receive the ID byte. The ID byte is returned unmirrored.
- R7: Payload bytes of program frames are sent bit-mirrored, and payload bytes received by data read are returned bit-mirrored. The status-write byte and the status-read byte pass through unmirrored.
- R8: Sector erase addresses the first byte of the sector, req_addr << SECT_LG2, truncated to 24 bits.
- R9: Receive bytes are clocked in by sending 0x00. Bytes received while command, address or dummy bytes are sent produce no `rd_valid` pulse. `rd_valid` pulses exactly once per requested result byte.
- R10: `link_go` is asserted only while `cs_n` is low, never in two consecutive cycles, and `wr_take` pulses only inside a frame.
- R11: `done` is a single-cycle pulse per request, coinciding with `req_ready` high. A data read or program with count 0, and class codes 6 and 7, finish with `done` and open no frame.
- R12: After reset `cs_n` is high, `req_ready` is high, and `link_go`, `done` and `rd_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present; taken when req_ready is high |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_op | input | 3 | Transaction class code |
| req_addr | input | 24 | Byte offset, or sector index for erase |
| req_len | input | LEN_W | Byte count for data read and program |
| wr_data | input | 8 | Current outgoing data byte from the requester |
| wr_take | output | 1 | Pulse: wr_data consumed, present the next byte |
| rd_data | output | 8 | Received result byte |
| rd_valid | output | 1 | Pulse: rd_data holds a new result byte |
| done | output | 1 | Pulse: request finished |
| cs_n | output | 1 | Flash chip select, active low |
| link_go | output | 1 | Pulse: start shifting link_tx |
| link_tx | output | 8 | Byte to shift out |
| link_done | input | 1 | Pulse from shifter: byte exchange finished |
| link_rx | input | 8 | Byte shifted in during the last exchange |

## Verification
The bound checker watches the link discipline on every cycle. It checks that a byte starts only inside a frame, that only one byte is in flight, that a write-enable frame comes before every program, erase and status-write frame, and that `done` is a one-cycle pulse with the sequencer idle. The bench's flash model is the only way to show the rest. It covers the frame contents and order, the page split and chunk addresses, the number of polls against a scripted busy flag whose byte also carries bit 1, the mirroring of payload bytes against the plain status and ID bytes, and the frameless completion of empty and reserved requests.

// File: rtl/sflash_pkg.sv
`timescale 1ns/1ps
package sflash_pkg;

   typedef enum logic [2:0] {
      OP_RDID  = 3'd0,
      OP_RDSR  = 3'd1,
      OP_WRSR  = 3'd2,
      OP_READ  = 3'd3,
      OP_PROG  = 3'd4,
      OP_ERASE = 3'd5,
      OP_RSV6  = 3'd6,
      OP_RSV7  = 3'd7
   } op_e;

   typedef enum logic [3:0] {
      S_IDLE, S_WEN, S_GAP, S_CMD, S_ADR, S_DUM, S_DAT, S_PCMD, S_PRD, S_DONE
   } st_e;

   localparam logic [7:0] CMD_WEN  = 8'h06;
   localparam logic [7:0] CMD_RDSR = 8'h05;
   localparam logic [7:0] CMD_FILL = 8'h00;

   function automatic logic [7:0] cmd_of(input op_e o);
      case (o)
         OP_RDID:  return 8'hAB;
         OP_RDSR:  return 8'h05;
         OP_WRSR:  return 8'h01;
         OP_READ:  return 8'h03;
         OP_PROG:  return 8'h02;
         OP_ERASE: return 8'hD8;
         default:  return 8'h00;
      endcase
   endfunction

   function automatic logic needs_wen(input op_e o);
      return (o == OP_WRSR) || (o == OP_PROG) || (o == OP_ERASE);
   endfunction

endpackage

// File: rtl/sflash_bitrev.sv
`timescale 1ns/1ps
module sflash_bitrev #(
   parameter int W = 8
) (
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   for (genvar i = 0; i < W; i++) begin : g_bit
      assign q[i] = d[W-1-i];
   end
endmodule

// File: rtl/sflash_chunk.sv
`timescale 1ns/1ps
module sflash_chunk #(
   parameter int PAGE_LG2 = 8,
   parameter int LEN_W    = 16
) (
   input  logic [23:0]      addr,
   input  logic [LEN_W-1:0] rem,
   output logic [LEN_W-1:0] chunk
);
   localparam logic [LEN_W-1:0] PAGE = LEN_W'(1) << PAGE_LG2;

   logic [LEN_W-1:0] room;

   assign room  = PAGE - LEN_W'(addr[PAGE_LG2-1:0]);
   assign chunk = (rem < room) ? rem : room;
endmodule

// File: rtl/sflash_seq.sv
`timescale 1ns/1ps
module sflash_seq
   import sflash_pkg::*;
#(
   parameter int PAGE_LG2 = 8,
   parameter int SECT_LG2 = 16,
   parameter int LEN_W    = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [2:0]       req_op,
   input  logic [23:0]      req_addr,
   input  logic [LEN_W-1:0] req_len,
   input  logic [7:0]       wr_data,
   output logic             wr_take,
   output logic [7:0]       rd_data,
   output logic             rd_valid,
   output logic             done,
   output logic             cs_n,
   output logic             link_go,
   output logic [7:0]       link_tx,
   input  logic             link_done,
   input  logic [7:0]       link_rx
);
   localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

   if (PAGE_LG2 < 1 || PAGE_LG2 > 20) begin : g_bad_page
      $error("sflash_seq: PAGE_LG2 out of range");
   end
   if (SECT_LG2 < PAGE_LG2 || SECT_LG2 > 23) begin : g_bad_sect
      $error("sflash_seq: SECT_LG2 must lie between PAGE_LG2 and 23");
   end
   if (LEN_W <= PAGE_LG2) begin : g_bad_len
      $error("sflash_seq: LEN_W must exceed PAGE_LG2");
   end

   st_e              st, after;
   op_e              op;
   logic [23:0]      addr;
   logic [LEN_W-1:0] rem, cnt, chunk;
   logic [1:0]       idx;
   logic             pend, sending, adv;
   logic [7:0]       tx_rev, rx_rev;

   sflash_bitrev #(.W(8)) u_rev_tx (.d(wr_data), .q(tx_rev));
   sflash_bitrev #(.W(8)) u_rev_rx (.d(link_rx), .q(rx_rev));
   sflash_chunk #(.PAGE_LG2(PAGE_LG2), .LEN_W(LEN_W)) u_chunk (
      .addr(addr), .rem(rem), .chunk(chunk));

   assign sending   = (st == S_WEN) || (st == S_CMD) || (st == S_ADR) || (st == S_DUM) ||
                      (st == S_DAT) || (st == S_PCMD) || (st == S_PRD);
   assign link_go   = sending && !pend;
   assign adv       = pend && link_done;
   assign req_ready = (st == S_IDLE);

   always_comb begin
      link_tx = CMD_FILL;
      case (st)
         S_WEN:  link_tx = CMD_WEN;
         S_CMD:  link_tx = cmd_of(op);
         S_ADR:  link_tx = (idx == 2'd0) ? addr[23:16] : (idx == 2'd1) ? addr[15:8] : addr[7:0];
         S_DAT:  link_tx = (op == OP_PROG) ? tx_rev : (op == OP_WRSR) ? wr_data : CMD_FILL;
         S_PCMD: link_tx = CMD_RDSR;
         default: link_tx = CMD_FILL;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= S_IDLE;
         after    <= S_IDLE;
         op       <= OP_RDID;
         addr     <= '0;
         rem      <= '0;
         cnt      <= '0;
         idx      <= '0;
         pend     <= 1'b0;
         cs_n     <= 1'b1;
         done     <= 1'b0;
         rd_valid <= 1'b0;
         rd_data  <= '0;
         wr_take  <= 1'b0;
      end else begin
         done     <= 1'b0;
         rd_valid <= 1'b0;
         wr_take  <= link_go && (st == S_DAT) && ((op == OP_PROG) || (op == OP_WRSR));
         if (link_go) pend <= 1'b1;
         if (adv)     pend <= 1'b0;
         case (st)
            S_IDLE: if (req_valid) begin
               op   <= op_e'(req_op);
               rem  <= req_len;
               addr <= (op_e'(req_op) == OP_ERASE) ? (req_addr << SECT_LG2) : req_addr;
               if (op_e'(req_op) == OP_RSV6 || op_e'(req_op) == OP_RSV7 ||
                   ((op_e'(req_op) == OP_READ || op_e'(req_op) == OP_PROG) && req_len == '0))
                  st <= S_DONE;
               else begin
                  cs_n <= 1'b0;
                  st   <= needs_wen(op_e'(req_op)) ? S_WEN : S_CMD;
               end
            end
            S_WEN: if (adv) begin
               cs_n  <= 1'b1;
               st    <= S_GAP;
               after <= S_CMD;
            end
            S_GAP: begin
               cs_n <= 1'b0;
               st   <= after;
            end
            S_CMD: if (adv) begin
               idx <= '0;
               cnt <= ONE;
               case (op)
                  OP_RDID:                   st <= S_DUM;
                  OP_RDSR, OP_WRSR:          st <= S_DAT;
                  default:                   st <= S_ADR;
               endcase
            end
            S_ADR: if (adv) begin
               idx <= idx + 2'd1;
               if (idx == 2'd2) begin
                  if (op == OP_ERASE) begin
                     cs_n  <= 1'b1;
                     st    <= S_GAP;
                     after <= S_PCMD;
                  end else begin
                     cnt <= (op == OP_PROG) ? chunk : rem;
                     st  <= S_DAT;
                  end
               end
            end
            S_DUM: if (adv) begin
               idx <= idx + 2'd1;
               if (idx == 2'd2) st <= S_DAT;
            end
            S_DAT: if (adv) begin
               cnt <= cnt - ONE;
               if (op == OP_READ || op == OP_PROG) begin
                  addr <= addr + 24'(1);
                  rem  <= rem - ONE;
               end
               if (op != OP_PROG && op != OP_WRSR) begin
                  rd_valid <= 1'b1;
                  rd_data  <= (op == OP_READ) ? rx_rev : link_rx;
               end
               if (cnt == ONE) begin
                  cs_n <= 1'b1;
                  if (op == OP_PROG) begin
                     st    <= S_GAP;
                     after <= S_PCMD;
                  end else
                     st <= S_DONE;
               end
            end
            S_PCMD: if (adv) st <= S_PRD;
            S_PRD: if (adv) begin
               cs_n <= 1'b1;
               if (link_rx[0]) begin
                  st    <= S_GAP;
                  after <= S_PCMD;
               end else if (op == OP_PROG && rem != '0) begin
                  st    <= S_GAP;
                  after <= S_WEN;
               end else
                  st <= S_DONE;
            end
            S_DONE: begin
               done <= 1'b1;
               st   <= S_IDLE;
            end
            default: st <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/sflash_seq_chk.sv
`timescale 1ns/1ps
module sflash_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cs_n,
   input logic       link_go,
   input logic [7:0] link_tx,
   input logic       done,
   input logic       req_ready,
   input logic       wr_take
);
   logic first, armed, guarded;

   assign guarded = (link_tx == 8'h02) || (link_tx == 8'hD8) || (link_tx == 8'h01);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         first <= 1'b1;
         armed <= 1'b0;
      end else begin
         if (cs_n)         first <= 1'b1;
         else if (link_go) first <= 1'b0;
         if (link_go && first) begin
            if (link_tx == 8'h06) armed <= 1'b1;
            else if (guarded)     armed <= 1'b0;
         end
      end
   end

   p_go_framed_r10: assert property (@(posedge clk) disable iff (!rst_n)
      link_go |-> !cs_n);
   p_one_in_flight_r10: assert property (@(posedge clk) disable iff (!rst_n)
      link_go |=> !link_go);
   p_take_framed_r10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_take |-> !cs_n);
   p_wen_prefix_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (link_go && first && guarded) |-> armed);
   p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> req_ready);
endmodule

bind sflash_seq sflash_seq_chk u_chk (
   .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .link_go(link_go), .link_tx(link_tx),
   .done(done), .req_ready(req_ready), .wr_take(wr_take));

// File: tb/sflash_seq_test.sv
`timescale 1ns/1ps
module sflash_seq_test;
   localparam int LEN_W = 16;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic             rst_n = 1'b0;
   logic             req_valid = 1'b0;
   logic             req_ready;
   logic [2:0]       req_op = '0;
   logic [23:0]      req_addr = '0;
   logic [LEN_W-1:0] req_len = '0;
   logic [7:0]       wr_data;
   logic             wr_take;
   logic [7:0]       rd_data;
   logic             rd_valid;
   logic             done;
   logic             cs_n;
   logic             link_go;
   logic [7:0]       link_tx;
   logic             link_done = 1'b0;
   logic [7:0]       link_rx = '0;

   sflash_seq #(.PAGE_LG2(8), .SECT_LG2(16), .LEN_W(LEN_W)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_op(req_op), .req_addr(req_addr), .req_len(req_len), .wr_data(wr_data),
      .wr_take(wr_take), .rd_data(rd_data), .rd_valid(rd_valid), .done(done),
      .cs_n(cs_n), .link_go(link_go), .link_tx(link_tx), .link_done(link_done),
      .link_rx(link_rx));

   int n_cmp = 0, n_bad = 0, cyc = 0;
   bit finished = 1'b0;

   logic [7:0] log_b [0:1023];
   int         fstart [0:63];
   int         flen   [0:63];
   logic [7:0] rd_log [0:511];
   logic [7:0] wdat   [0:511];
   int nfr, nlog, nrd, ndone, wr_ptr, busy_left, lat, pos;
   logic [7:0] resp, fb;
   logic prev_cs = 1'b1;

   assign wr_data = wdat[wr_ptr & 511];

   function automatic logic [7:0] rev8(input logic [7:0] v);
      logic [7:0] r;
      for (int i = 0; i < 8; i++) r[i] = v[7-i];
      return r;
   endfunction

   function automatic logic [7:0] pat(input int k);
      return 8'((k * 37 + 11) & 255);
   endfunction

   // Flash and shifter model, all on the falling edge
   always @(negedge clk) begin
      cyc++;
      link_done = 1'b0;
      if (lat != 0) begin
         lat--;
         if (lat == 0) begin
            link_done = 1'b1;
            link_rx   = resp;
         end
      end
      if (prev_cs && !cs_n && nfr < 64) begin
         fstart[nfr] = nlog;
         flen[nfr]   = 0;
         nfr++;
      end
      prev_cs = cs_n;
      if (link_go && nfr > 0 && nlog < 1024) begin
         pos  = flen[nfr-1];
         fb   = (pos == 0) ? link_tx : log_b[fstart[nfr-1]];
         resp = 8'hE5;
         if (pos == 0 && (link_tx == 8'h02 || link_tx == 8'hD8)) busy_left = 2;
         if (fb == 8'h05 && pos == 1) begin
            if (busy_left > 0) begin
               resp = 8'h03;
               busy_left--;
            end else
               resp = 8'h82;
         end
         if (fb == 8'hAB && pos == 4) resp = 8'h14;
         if (fb == 8'h03 && pos >= 4) resp = pat(pos - 4);
         log_b[nlog] = link_tx;
         nlog++;
         flen[nfr-1]++;
         lat = 2;
      end
      if (rd_valid && nrd < 512) begin
         rd_log[nrd] = rd_data;
         nrd++;
      end
      if (done) ndone++;
      if (wr_take) wr_ptr++;
   end

   task automatic chk(input string tag, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   function automatic int fbyte(input int f, input int k);
      return int'(log_b[fstart[f] + k]);
   endfunction

   task automatic run_op(input int op, input int addr, input int len);
      @(posedge clk);
      nfr = 0; nlog = 0; nrd = 0; ndone = 0; wr_ptr = 0; busy_left = 0;
      @(negedge clk);
      req_op    = 3'(op);
      req_addr  = 24'(addr);
      req_len   = LEN_W'(len);
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      for (int t = 0; t < 20000 && ndone == 0; t++) @(negedge clk);
      repeat (4) @(negedge clk);
      @(posedge clk);
      chk("R11 one done pulse per request", ndone, 1);
   endtask

   task automatic t_reset;
      chk("R12 cs_n high after reset", int'(cs_n), 1);
      chk("R12 req_ready high after reset", int'(req_ready), 1);
      chk("R12 link_go low after reset", int'(link_go), 0);
      chk("R12 done/rd_valid low after reset", int'(done | rd_valid), 0);
   endtask

   task automatic t_status_read;
      run_op(1, 0, 0);
      chk("R1 status read frame count", nfr, 1);
      chk("R1 status read length", flen[0], 2);
      chk("R1 status read opcode", fbyte(0, 0), 8'h05);
      chk("R9 status read filler", fbyte(0, 1), 8'h00);
      chk("R9 status read result count", nrd, 1);
      chk("R7 status byte not mirrored", int'(rd_log[0]), 8'h82);
   endtask

   task automatic t_read_id;
      run_op(0, 0, 0);
      chk("R6 identify frame count", nfr, 1);
      chk("R6 identify length", flen[0], 5);
      chk("R6 identify opcode", fbyte(0, 0), 8'hAB);
      for (int k = 1; k < 5; k++) chk("R6 identify dummy/filler byte", fbyte(0, k), 8'h00);
      chk("R9 identify result count", nrd, 1);
      chk("R6 identify byte unmirrored", int'(rd_log[0]), 8'h14);
   endtask

   task automatic t_read_data;
      run_op(3, 24'h123456, 5);
      chk("R2 read frame count", nfr, 1);
      chk("R2 read length", flen[0], 9);
      chk("R1 read opcode", fbyte(0, 0), 8'h03);
      chk("R2 read address high", fbyte(0, 1), 8'h12);
      chk("R2 read address mid", fbyte(0, 2), 8'h34);
      chk("R2 read address low", fbyte(0, 3), 8'h56);
      for (int k = 4; k < 9; k++) chk("R9 read filler byte", fbyte(0, k), 8'h00);
      chk("R9 read result count", nrd, 5);
      for (int k = 0; k < 5; k++) chk("R7 read data mirrored", int'(rd_log[k]), int'(rev8(pat(k))));
   endtask

   task automatic t_program_split;
      for (int i = 0; i < 512; i++) wdat[i] = 8'(8'h31 + i * 7);
      run_op(4, 24'h0000FA, 10);
      chk("R5 program frame count", nfr, 10);
      chk("R3 wen frame 0", fbyte(0, 0), 8'h06);
      chk("R3 wen frame 0 alone", flen[0], 1);
      chk("R5 first chunk length", flen[1], 10);
      chk("R1 program opcode", fbyte(1, 0), 8'h02);
      chk("R2 chunk 1 address", (fbyte(1, 1) << 16) | (fbyte(1, 2) << 8) | fbyte(1, 3), 24'h0000FA);
      for (int k = 0; k < 6; k++) chk("R7 program data mirrored", fbyte(1, 4 + k), int'(rev8(wdat[k])));
      for (int f = 2; f < 5; f++) chk("R4 poll frame opcode", fbyte(f, 0), 8'h05);
      chk("R3 wen before chunk 2", fbyte(5, 0), 8'h06);
      chk("R5 second chunk length", flen[6], 8);
      chk("R5 chunk 2 address", (fbyte(6, 1) << 16) | (fbyte(6, 2) << 8) | fbyte(6, 3), 24'h000100);
      for (int k = 0; k < 4; k++) chk("R7 chunk 2 data mirrored", fbyte(6, 4 + k), int'(rev8(wdat[6 + k])));
      chk("R4 final poll frame", fbyte(9, 0), 8'h05);
      chk("R10 bytes taken", wr_ptr, 10);
   endtask

   task automatic t_program_page;
      run_op(4, 24'h000100, 256);
      chk("R5 aligned full page frame count", nfr, 5);
      chk("R5 aligned full page length", flen[1], 260);
      chk("R5 aligned last byte", fbyte(1, 259), int'(rev8(wdat[255])));
   endtask

   task automatic t_erase;
      run_op(5, 3, 0);
      chk("R8 erase frame count", nfr, 5);
      chk("R3 erase wen", fbyte(0, 0), 8'h06);
      chk("R1 erase opcode", fbyte(1, 0), 8'hD8);
      chk("R8 erase address", (fbyte(1, 1) << 16) | (fbyte(1, 2) << 8) | fbyte(1, 3), 24'h030000);
      chk("R8 erase frame length", flen[1], 4);
      chk("R4 erase polls", fbyte(4, 0), 8'h05);
   endtask

   task automatic t_status_write;
      wdat[0] = 8'h9C;
      run_op(2, 0, 0);
      chk("R3 status write frame count", nfr, 2);
      chk("R3 status write wen", fbyte(0, 0), 8'h06);
      chk("R1 status write opcode", fbyte(1, 0), 8'h01);
      chk("R7 status write byte unmirrored", fbyte(1, 1), 8'h9C);
      chk("R9 status write returns nothing", nrd, 0);
   endtask

   task automatic t_empty;
      run_op(3, 24'h000010, 0);
      chk("R11 zero-length read opens no frame", nfr, 0);
      run_op(4, 24'h000010, 0);
      chk("R11 zero-length program opens no frame", nfr, 0);
      run_op(7, 0, 4);
      chk("R11 reserved class opens no frame", nfr, 0);
   endtask

   initial begin
      nfr = 0; nlog = 0; nrd = 0; ndone = 0; wr_ptr = 0; busy_left = 0; lat = 0;
      for (int i = 0; i < 512; i++) wdat[i] = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_status_read();
      t_read_id();
      t_read_data();
      t_program_split();
      t_program_page();
      t_erase();
      t_status_write();
      t_empty();
      if (!finished) begin
         finished = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      wait (cyc > 150000);
      if (!finished) begin
         finished = 1'b1;
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule